// File: doc/BRIEF.md
# Two-Phase Opcode Class Decoder

This block sits between the fetch and execute stages of a small 32-bit RISC pipeline. Each new instruction arrives as a toggle on one request wire (two-phase signalling), with the word already stable (bundled data). The block reads the two class bits at the top of the opcode and converts that single event into a toggle on exactly one of three class request wires: J-type, R-type or I-type. On the same clock edge it registers the instruction fields: the four remaining opcode bits (decoded later, in execute), the register addresses, the function field, the immediate and the PC offset.

The upstream acknowledge toggles only after the stage that owns the selected class has acknowledged its event by bringing its acknowledge toggle level with the class request. A class code of 00 is illegal. It raises an error flag and produces no class event, but the upstream acknowledge is still returned so that the pipeline keeps moving. Every toggle is a register sampled on one clock. Incoming toggles pass through a configurable synchroniser chain, `SYNC_STAGES` flops deep, which may be zero.

Bit numbering in the requirements is the conventional one: bit 31 is the most significant bit of `instr_i`. Opcode bit 0 is word bit 31 and opcode bit 5 is word bit 26.

Top module: `opc_evt_decoder`

## Requirements
- R1: The class code is `instr_i[31:30]`. The value 11 toggles `cls_req_o[0]` (J-type), 10 toggles `cls_req_o[1]` (R-type) and 01 toggles `cls_req_o[2]` (I-type).
- R2: Each accepted request toggles at most one bit of `cls_req_o`, and the other two bits keep their values.
- R3: A request is accepted when `req_tgl_i` differs from `ack_tgl_o` and no transaction is open. The class event and the registered fields appear together, SYNC_STAGES+1 clock edges after the request toggle (3 with the defaults). Fields change at no other time.
- R4: `sub_op_o` carries `instr_i[29:26]` unchanged, whatever the class.
- R5: For an R-type word: `rs1_o`=`instr_i[25:21]`, `rs2_o`=`instr_i[20:16]`, `rd_o`=`instr_i[15:11]` and `func_o`=`instr_i[10:0]`.
- R6: For an I-type word: `rs1_o`=`instr_i[25:21]`, `rd_o`=`instr_i[20:16]` and `imm_o`=`instr_i[15:0]`.
- R7: For a J-type word: `off_o`=`instr_i[25:0]`.
- R8: `ack_tgl_o` toggles only after `dn_ack_i[k]` becomes equal to `cls_req_o[k]` for the selected class k. It toggles SYNC_STAGES+1 edges after that downstream toggle. Toggles on the acknowledge wires of unselected classes leave `ack_tgl_o` unchanged.
- R9: A class code of 00 toggles no class output and sets `err_o` to 1. It toggles `ack_tgl_o` with the R3 latency. `err_o` returns to 0 when the next legal request is accepted.
- R10: After reset, `cls_req_o`, `ack_tgl_o`, `err_o` and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word, stable before the request toggle |
| req_tgl_i | input | 1 | Upstream request toggle |
| dn_ack_i | input | 3 | Downstream acknowledge toggles, index 0 J, 1 R, 2 I |
| cls_req_o | output | 3 | Class request toggles, index 0 J, 1 R, 2 I |
| ack_tgl_o | output | 1 | Acknowledge toggle returned upstream |
| err_o | output | 1 | Illegal class code seen on the last accepted request |
| sub_op_o | output | 4 | Opcode bits forwarded to execute |
| rs1_o | output | 5 | First source register address |
| rs2_o | output | 5 | Second source register address |
| rd_o | output | 5 | Destination register address, placed according to class |
| func_o | output | 11 | R-type function field |
| imm_o | output | 16 | I-type immediate |
| off_o | output | 26 | J-type PC offset |

## Verification
A corrupted open-transaction state shows up at the ports as one of three faults: an acknowledge that never returns, a second class toggle, or an acknowledge that toggles before the downstream stage has replied. The bench samples each of these one edge before and exactly at the expected latency, so an off-by-one in the synchroniser or the controller is caught at once. A wrong class latch or wrong field slicing shows on the first event of the affected class, because every class is exercised with distinct field values. Stray acknowledges on idle classes and an illegal code check that the pending-class mask really gates completion.

// File: rtl/opc_evt_pkg.sv
package opc_evt_pkg;

   localparam int CLS_W   = 2;
   localparam int CLS_CNT = 3;
   localparam int IDX_J   = 0;
   localparam int IDX_R   = 1;
   localparam int IDX_I   = 2;

   typedef enum logic [CLS_W-1:0] {
      CLS_ILLEGAL = 2'b00,
      CLS_ITYPE   = 2'b01,
      CLS_RTYPE   = 2'b10,
      CLS_JTYPE   = 2'b11
   } opc_cls_e;

   function automatic logic [CLS_CNT-1:0] cls_onehot(input opc_cls_e c);
      logic [CLS_CNT-1:0] v;
      v = '0;
      case (c)
         CLS_JTYPE: v[IDX_J] = 1'b1;
         CLS_RTYPE: v[IDX_R] = 1'b1;
         CLS_ITYPE: v[IDX_I] = 1'b1;
         default:   v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/opc_tog_sync.sv
module opc_tog_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES < 0) begin : g_bad_depth
         $error("opc_tog_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= din;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end

         assign dout = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/opc_field_split.sv
module opc_field_split
   import opc_evt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int OPC_W  = 6,
   parameter int REG_W  = 5
) (
   input  logic [DATA_W-1:0]                instr,
   output opc_cls_e                         cls,
   output logic [OPC_W-CLS_W-1:0]           sub_op,
   output logic [REG_W-1:0]                 rs1,
   output logic [REG_W-1:0]                 rs2,
   output logic [REG_W-1:0]                 rd,
   output logic [DATA_W-OPC_W-3*REG_W-1:0]  func,
   output logic [DATA_W-OPC_W-2*REG_W-1:0]  imm,
   output logic [DATA_W-OPC_W-1:0]          off
);

   localparam int SUB_W  = OPC_W - CLS_W;
   localparam int OFF_W  = DATA_W - OPC_W;
   localparam int IMM_W  = OFF_W - 2*REG_W;
   localparam int FUNC_W = OFF_W - 3*REG_W;
   localparam int CLS_HI = DATA_W - 1;
   localparam int SUB_HI = CLS_HI - CLS_W;
   localparam int RS1_HI = OFF_W - 1;
   localparam int RS2_HI = RS1_HI - REG_W;
   localparam int RRD_HI = RS2_HI - REG_W;
   localparam int IRD_HI = RS2_HI;

   logic [REG_W-1:0] rd_rtype;
   logic [REG_W-1:0] rd_itype;

   assign cls      = opc_cls_e'(instr[CLS_HI -: CLS_W]);
   assign sub_op   = instr[SUB_HI -: SUB_W];
   assign rs1      = instr[RS1_HI -: REG_W];
   assign rs2      = instr[RS2_HI -: REG_W];
   assign rd_rtype = instr[RRD_HI -: REG_W];
   assign rd_itype = instr[IRD_HI -: REG_W];
   assign func     = instr[FUNC_W-1:0];
   assign imm      = instr[IMM_W-1:0];
   assign off      = instr[OFF_W-1:0];

   always_comb begin
      case (cls)
         CLS_ITYPE: rd = rd_itype;
         default:   rd = rd_rtype;
      endcase
   end

endmodule

// File: rtl/opc_class_select.sv
module opc_class_select #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire,
   input  logic [N-1:0] sel,
   output logic [N-1:0] tog
);

   generate
      for (genvar k = 0; k < N; k++) begin : g_sel
         logic tog_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              tog_q <= 1'b0;
            else if (fire && sel[k]) tog_q <= ~tog_q;
         end

         assign tog[k] = tog_q;
      end
   endgenerate

endmodule

// File: rtl/opc_hs_ctrl.sv
module opc_hs_ctrl #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_s,
   input  logic [N-1:0] ack_s,
   input  logic [N-1:0] cls_tog,
   input  logic [N-1:0] sel,
   output logic         fire,
   output logic         ack_tog,
   output logic         err
);

   logic         busy_q;
   logic [N-1:0] pend_q;
   logic         ack_q;
   logic         err_q;
   logic         legal;
   logic         done;

   assign legal = |sel;
   assign fire  = !busy_q && (req_s != ack_q);
   assign done  = busy_q && (|(pend_q & ~(ack_s ^ cls_tog)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         ack_q  <= 1'b0;
         err_q  <= 1'b0;
      end else if (fire) begin
         if (legal) begin
            busy_q <= 1'b1;
            pend_q <= sel;
            err_q  <= 1'b0;
         end else begin
            ack_q  <= ~ack_q;
            err_q  <= 1'b1;
         end
      end else if (done) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         ack_q  <= ~ack_q;
      end
   end

   assign ack_tog = ack_q;
   assign err     = err_q;

endmodule

// File: rtl/opc_evt_decoder.sv
module opc_evt_decoder
   import opc_evt_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int OPC_W       = 6,
   parameter int REG_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [DATA_W-1:0]                  instr_i,
   input  logic                               req_tgl_i,
   input  logic [2:0]                         dn_ack_i,
   output logic [2:0]                         cls_req_o,
   output logic                               ack_tgl_o,
   output logic                               err_o,
   output logic [OPC_W-2-1:0]                 sub_op_o,
   output logic [REG_W-1:0]                   rs1_o,
   output logic [REG_W-1:0]                   rs2_o,
   output logic [REG_W-1:0]                   rd_o,
   output logic [DATA_W-OPC_W-3*REG_W-1:0]    func_o,
   output logic [DATA_W-OPC_W-2*REG_W-1:0]    imm_o,
   output logic [DATA_W-OPC_W-1:0]            off_o
);

   localparam int SUB_W  = OPC_W - CLS_W;
   localparam int OFF_W  = DATA_W - OPC_W;
   localparam int IMM_W  = OFF_W - 2*REG_W;
   localparam int FUNC_W = OFF_W - 3*REG_W;

   generate
      if (CLS_CNT != 3) begin : g_bad_cnt
         $error("opc_evt_decoder: exactly three classes are supported");
      end
      if (OPC_W <= CLS_W) begin : g_bad_opc
         $error("opc_evt_decoder: opcode must be wider than the class code");
      end
      if (FUNC_W < 1) begin : g_bad_fields
         $error("opc_evt_decoder: word too narrow for the R-type layout");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("opc_evt_decoder: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic                 req_s;
   logic [CLS_CNT-1:0]   ack_s;
   logic [CLS_CNT-1:0]   sel;
   logic [CLS_CNT-1:0]   cls_tog;
   logic                 fire;
   opc_cls_e             cls;
   logic [SUB_W-1:0]     sub_d;
   logic [REG_W-1:0]     rs1_d, rs2_d, rd_d;
   logic [FUNC_W-1:0]    func_d;
   logic [IMM_W-1:0]     imm_d;
   logic [OFF_W-1:0]     off_d;

   opc_tog_sync #(.W(1 + CLS_CNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({req_tgl_i, dn_ack_i}),
      .dout  ({req_s, ack_s})
   );

   opc_field_split #(.DATA_W(DATA_W), .OPC_W(OPC_W), .REG_W(REG_W)) u_split (
      .instr  (instr_i),
      .cls    (cls),
      .sub_op (sub_d),
      .rs1    (rs1_d),
      .rs2    (rs2_d),
      .rd     (rd_d),
      .func   (func_d),
      .imm    (imm_d),
      .off    (off_d)
   );

   assign sel = cls_onehot(cls);

   opc_hs_ctrl #(.N(CLS_CNT)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_s   (req_s),
      .ack_s   (ack_s),
      .cls_tog (cls_tog),
      .sel     (sel),
      .fire    (fire),
      .ack_tog (ack_tgl_o),
      .err     (err_o)
   );

   opc_class_select #(.N(CLS_CNT)) u_select (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .sel   (sel),
      .tog   (cls_tog)
   );

   assign cls_req_o = cls_tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_op_o <= '0;
         rs1_o    <= '0;
         rs2_o    <= '0;
         rd_o     <= '0;
         func_o   <= '0;
         imm_o    <= '0;
         off_o    <= '0;
      end else if (fire) begin
         sub_op_o <= sub_d;
         rs1_o    <= rs1_d;
         rs2_o    <= rs2_d;
         rd_o     <= rd_d;
         func_o   <= func_d;
         imm_o    <= imm_d;
         off_o    <= off_d;
      end
   end

endmodule

// File: rtl/opc_evt_decoder_chk.sv
module opc_evt_decoder_chk #(
   parameter int FLD_W = 72
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cls_req,
   input logic             ack_tgl,
   input logic             err,
   input logic [FLD_W-1:0] fields
);

   AST_ONE_CLASS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cls_req ^ $past(cls_req)) <= 1); // R2

   AST_ILLEGAL_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (cls_req == $past(cls_req))); // R9

   AST_ILLEGAL_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (ack_tgl != $past(ack_tgl))); // R9

   AST_ACK_APART_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_tgl != $past(ack_tgl)) |-> (cls_req == $past(cls_req))); // R8

   AST_FIELDS_BUNDLED: assert property (@(posedge clk) disable iff (!rst_n)
      (fields != $past(fields)) |->
         ((cls_req != $past(cls_req)) || (ack_tgl != $past(ack_tgl)))); // R3

endmodule

bind opc_evt_decoder opc_evt_decoder_chk #(
   .FLD_W((OPC_W - 2) + 3*REG_W + (DATA_W-OPC_W-3*REG_W) + (DATA_W-OPC_W-2*REG_W) + (DATA_W-OPC_W))
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cls_req (cls_req_o),
   .ack_tgl (ack_tgl_o),
   .err     (err_o),
   .fields  ({sub_op_o, rs1_o, rs2_o, rd_o, func_o, imm_o, off_o})
);

// File: tb/opc_evt_decoder_tb.sv
`timescale 1ns/1ps
module opc_evt_decoder_tb;

   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic        req = 1'b0;
   logic [2:0]  dn_ack = '0;
   logic [2:0]  cls_req;
   logic        ack_o;
   logic        err;
   logic [3:0]  sub_op;
   logic [4:0]  rs1, rs2, rd;
   logic [10:0] func;
   logic [15:0] imm;
   logic [25:0] off;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   opc_evt_decoder #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .instr_i(instr), .req_tgl_i(req),
      .dn_ack_i(dn_ack), .cls_req_o(cls_req), .ack_tgl_o(ack_o), .err_o(err),
      .sub_op_o(sub_op), .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd),
      .func_o(func), .imm_o(imm), .off_o(off)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Legal request of class idx (0 J, 1 R, 2 I), full handshake
   task automatic t_legal(input logic [31:0] w, input int idx);
      logic [2:0] prev_cls;
      logic       prev_ack;
      logic [2:0] exp_cls;
      prev_cls = cls_req;
      prev_ack = ack_o;
      exp_cls  = prev_cls ^ (3'b001 << idx);
      instr = w;
      step(1);
      req = ~req;
      step(LAT - 1);
      chk(cls_req == prev_cls, "R3 class event too early", {29'd0, cls_req}, {29'd0, prev_cls});
      step(1);
      chk(cls_req == exp_cls, "R1/R2 class toggle", {29'd0, cls_req}, {29'd0, exp_cls});
      chk(sub_op == w[29:26], "R4 sub opcode", {28'd0, sub_op}, {28'd0, w[29:26]});
      chk(err == 1'b0, "R9 err cleared on legal", {31'd0, err}, 32'd0);
      chk(rs1 == w[25:21], "R5/R6 rs1", {27'd0, rs1}, {27'd0, w[25:21]});
      if (idx == 1) begin
         chk(rs2 == w[20:16], "R5 rs2", {27'd0, rs2}, {27'd0, w[20:16]});
         chk(rd == w[15:11], "R5 rd", {27'd0, rd}, {27'd0, w[15:11]});
         chk(func == w[10:0], "R5 func", {21'd0, func}, {21'd0, w[10:0]});
      end else if (idx == 2) begin
         chk(rd == w[20:16], "R6 rd", {27'd0, rd}, {27'd0, w[20:16]});
         chk(imm == w[15:0], "R6 imm", {16'd0, imm}, {16'd0, w[15:0]});
      end else begin
         chk(off == w[25:0], "R7 offset", {6'd0, off}, {6'd0, w[25:0]});
      end
      step(5);
      chk(ack_o == prev_ack, "R8 ack before downstream", {31'd0, ack_o}, {31'd0, prev_ack});
      dn_ack[idx] = ~dn_ack[idx];
      step(LAT - 1);
      chk(ack_o == prev_ack, "R8 ack too early", {31'd0, ack_o}, {31'd0, prev_ack});
      step(1);
      chk(ack_o == ~prev_ack, "R8 ack returned", {31'd0, ack_o}, {31'd0, ~prev_ack});
      chk(cls_req == exp_cls, "R2 no extra class event", {29'd0, cls_req}, {29'd0, exp_cls});
   endtask

   task automatic t_illegal(input logic [31:0] w);
      logic [2:0] prev_cls;
      logic       prev_ack;
      prev_cls = cls_req;
      prev_ack = ack_o;
      instr = w;
      step(1);
      req = ~req;
      step(LAT - 1);
      chk(ack_o == prev_ack, "R9 illegal ack too early", {31'd0, ack_o}, {31'd0, prev_ack});
      step(1);
      chk(ack_o == ~prev_ack, "R9 illegal ack returned", {31'd0, ack_o}, {31'd0, ~prev_ack});
      chk(err == 1'b1, "R9 err set", {31'd0, err}, 32'd1);
      step(4);
      chk(cls_req == prev_cls, "R9 no class event", {29'd0, cls_req}, {29'd0, prev_cls});
   endtask

   // R-type request; stray acks on J and I must not complete it
   task automatic t_stray(input logic [31:0] w);
      logic prev_ack;
      prev_ack = ack_o;
      instr = w;
      step(1);
      req = ~req;
      step(LAT);
      dn_ack[0] = ~dn_ack[0];
      dn_ack[2] = ~dn_ack[2];
      step(8);
      chk(ack_o == prev_ack, "R8 stray acks ignored", {31'd0, ack_o}, {31'd0, prev_ack});
      dn_ack[0] = ~dn_ack[0];
      dn_ack[2] = ~dn_ack[2];
      step(8);
      chk(ack_o == prev_ack, "R8 still waiting", {31'd0, ack_o}, {31'd0, prev_ack});
      dn_ack[1] = ~dn_ack[1];
      step(LAT);
      chk(ack_o == ~prev_ack, "R8 selected ack completes", {31'd0, ack_o}, {31'd0, ~prev_ack});
   endtask

   task automatic t_reset();
      step(1);
      chk(cls_req == 3'b000, "R10 class outputs", {29'd0, cls_req}, 32'd0);
      chk(ack_o == 1'b0, "R10 ack", {31'd0, ack_o}, 32'd0);
      chk(err == 1'b0, "R10 err", {31'd0, err}, 32'd0);
      chk({sub_op, rs1, rs2, rd} == 19'd0, "R10 fields", {13'd0, sub_op, rs1, rs2, rd}, 32'd0);
      chk({func, imm} == 27'd0 && off == 26'd0, "R10 wide fields", {5'd0, func, imm}, 32'd0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      step(3);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      step(2);
      t_reset();
      t_legal({2'b10, 4'h6, 5'd3, 5'd17, 5'd29, 11'h5A5}, 1);
      t_legal({2'b01, 4'h9, 5'd31, 5'd0, 16'hBEEF}, 2);
      t_legal({2'b11, 4'hF, 26'h2A5C3F1}, 0);
      t_illegal({2'b00, 30'h1234567});
      t_legal({2'b01, 4'h0, 5'd7, 5'd12, 16'h0001}, 2);
      t_illegal({2'b00, 30'h3FFFFFFF});
      t_legal({2'b10, 4'h3, 5'd1, 5'd2, 5'd4, 11'h7FF}, 1);
      t_stray({2'b10, 4'hA, 5'd9, 5'd10, 5'd11, 11'h001});
      t_legal({2'b11, 4'h1, 26'h0000001}, 0);
      step(4);
      summary();
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         summary();
      end
   end

endmodule